// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block runs the transmit side of a node's in-frame response on a shared, wired-priority serial bus. Software writes a three-bit response-type register. Bit 2 selects a single-byte response, bit 1 selects multi-byte response type 1, and bit 0 selects multi-byte response type 0. If several bits are set, a priority encoder picks one of them, and the register still reads back exactly what was written.

When a response is started, the sequencer waits for the end-of-data symbol. It then offers one active normalization symbol to the symbol transmitter, unless another responder's normalization symbol is seen first. After that it serialises the node's ID byte, MSB first, and compares every transmitted bit with the bit sampled back from the bus. On a lost arbitration it stops the byte and waits for the next byte slot. It then tries the whole byte again, and keeps doing so until its own byte appears in the response stream or the frame ends.

The transmit interface is valid/ready. While `tx_valid` is high and `tx_ready` is low, the offered symbol (`tx_norm`, `tx_bit`) stays stable, with two exceptions. A normalization offer is withdrawn in the cycle another node's normalization symbol is seen, and any offer is withdrawn by end-of-frame. The receive-side inputs are single-cycle pulses and cannot be stalled, because the bus cannot wait.

Top module: `ifr_tx_seq`

## Requirements
- R1: `cfg_rdata` returns the raw 3-bit value last written through `cfg_wr`/`cfg_wdata`, in the cycle after the write.
- R2: `cfg_eff` is the priority-resolved type, one-hot or zero. Bit 2 (single-byte) beats bit 1 (multi type 1), which beats bit 0 (multi type 0). For example, 011 resolves to 010 and 1xx resolves to 100.
- R3: A start pulse is accepted only while idle with a nonzero `cfg_eff`. On acceptance, `ifr_busy` rises and `ifr_type` holds the resolved type. A start with a zero type is ignored.
- R4: No symbol is offered before the end-of-data pulse. In the cycle after it, a normalization symbol is offered (`tx_valid`=1, `tx_norm`=1, `tx_bit`=1, where 1 is the active level).
- R5: If `bus_norm` is seen while the normalization symbol is pending, the offer is withdrawn at once and the sequencer proceeds straight to the first ID bit without sending its own normalization symbol.
- R6: ID bits are offered MSB first, one per handshake. The next bit is offered only after the bus echo (`rx_bit_vld`) of the previous bit. An unaccepted offer holds steady.
- R7: A transmitted 0 (passive) that echoes back as 1 (active) ends the attempt. No further bit is offered until the next `rx_byte_vld`, after which the byte is retried from its MSB.
- R8: When `rx_byte_vld` delivers a byte equal to `node_id` while waiting for a slot, `ifr_done` pulses for exactly one cycle, and the block then returns to idle with `ifr_type` cleared.
- R9: `bus_eof` while a response is in progress gives a one-cycle `ifr_abort` pulse, a return to idle and no `ifr_done`.
- R10: Synchronous reset clears the type register, the resolved type and the sequencer: busy, done, abort and `tx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Type register write strobe |
| cfg_wdata | input | 3 | Type value to write: bit2 single, bit1 multi-1, bit0 multi-0 |
| cfg_rdata | output | 3 | Raw readback of the type register |
| cfg_eff | output | 3 | Priority-resolved type |
| ifr_start | input | 1 | Request to respond to the current frame |
| node_id | input | 8 | The node's unique response byte |
| bus_eod | input | 1 | End-of-data symbol observed (pulse) |
| bus_eof | input | 1 | End-of-frame observed (pulse) |
| bus_norm | input | 1 | Another responder's normalization symbol observed |
| rx_bit_vld | input | 1 | Bus echo of the last transmitted bit is valid |
| rx_bit | input | 1 | Sampled bus level, 1 = active |
| rx_byte_vld | input | 1 | A complete response byte was received |
| rx_byte | input | 8 | Received response byte |
| tx_valid | output | 1 | Symbol offered to the symbol transmitter |
| tx_ready | input | 1 | Symbol transmitter accepts the offer |
| tx_norm | output | 1 | Offered symbol is the normalization symbol |
| tx_bit | output | 1 | Offered bit level, 1 = active |
| ifr_busy | output | 1 | A response is in progress |
| ifr_type | output | 3 | Type latched for the response in progress |
| ifr_done | output | 1 | Own byte seen on the bus (pulse) |
| ifr_abort | output | 1 | Frame ended before own byte was seen (pulse) |

## Verification
Several properties are checked on every cycle:
- the resolved type is always one-hot or zero and never empty while the raw value is nonzero;
- the latched type is one-hot exactly while busy;
- nothing is offered while idle, and an unaccepted ID bit holds steady;
- a normalization offer only rises straight after end-of-data;
- done and abort are single-cycle and end in idle.

Other behaviours need the bench's scenarios to show them: the MSB-first bit order against a chosen ID, the withdrawal when another responder's normalization is seen, the loss detection and retry from the MSB after a foreign byte, and the completion on the node's own byte.

// File: rtl/ifr_seq_pkg.sv
`timescale 1ns/1ps
package ifr_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_EOD,
    S_NORM_BIT,
    S_SEND_ID,
    S_WAIT_SLOT,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/ifr_type_cfg.sv
`timescale 1ns/1ps
// Response-type register with raw readback and a priority resolver.
module ifr_type_cfg #(
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [TYPE_W-1:0] wr_data,
  output logic [TYPE_W-1:0] raw_q,
  output logic [TYPE_W-1:0] eff
);
  always_ff @(posedge clk) begin
    if (rst)        raw_q <= '0;
    else if (wr_en) raw_q <= wr_data;
  end

  // The highest set bit wins; every lower bit is masked by all higher ones.
  for (genvar i = 0; i < TYPE_W; i++) begin : g_prio
    if (i == TYPE_W - 1) begin : g_top
      assign eff[i] = raw_q[i];
    end else begin : g_low
      assign eff[i] = raw_q[i] & ~(|raw_q[TYPE_W-1:i+1]);
    end
  end
endmodule

// File: rtl/ifr_id_tx.sv
`timescale 1ns/1ps
// ID byte serialiser with per-bit arbitration check against the bus echo.
module ifr_id_tx #(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [ID_W-1:0] id,
  input  logic            tx_ready,
  input  logic            echo_vld,
  input  logic            echo_bit,
  output logic            bit_valid,
  output logic            bit_val,
  output logic            seg_end,
  output logic            lost
);
  localparam int IDX_W = (ID_W > 1) ? $clog2(ID_W) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_W - 1);

  logic [IDX_W-1:0] idx;
  logic             await_echo;

  assign bit_val   = id[LAST - idx];
  assign bit_valid = en & ~await_echo;
  // A passive bit that reads back active means another node won.
  assign lost      = en & await_echo & echo_vld & ~bit_val & echo_bit;
  assign seg_end   = en & await_echo & echo_vld & (lost | (idx == LAST));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      idx        <= '0;
      await_echo <= 1'b0;
    end else if (await_echo) begin
      if (echo_vld && !seg_end) begin
        idx        <= idx + 1'b1;
        await_echo <= 1'b0;
      end
    end else if (tx_ready) begin
      await_echo <= 1'b1;
    end
  end
endmodule

// File: rtl/ifr_seq_ctrl.sv
`timescale 1ns/1ps
// Response sequencer: start, end-of-data wait, shared normalization, retries.
module ifr_seq_ctrl
  import ifr_seq_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [TYPE_W-1:0] eff_type,
  input  logic              bus_eod,
  input  logic              bus_eof,
  input  logic              bus_norm,
  input  logic              tx_ready,
  input  logic              seg_end,
  input  logic              rx_byte_vld,
  input  logic [ID_W-1:0]   rx_byte,
  input  logic [ID_W-1:0]   node_id,
  output seq_state_t        state,
  output logic [TYPE_W-1:0] act_type,
  output logic              norm_valid,
  output logic              done,
  output logic              abort
);
  seq_state_t nxt;
  logic       abort_n;
  logic       own_byte;

  assign own_byte   = (state == S_WAIT_SLOT) && rx_byte_vld && (rx_byte == node_id);
  assign norm_valid = (state == S_NORM_BIT) && !bus_norm;
  assign done       = (state == S_DONE);

  always_comb begin
    nxt     = state;
    abort_n = 1'b0;
    unique case (state)
      S_IDLE:      if (start && (|eff_type)) nxt = S_WAIT_EOD;
      S_WAIT_EOD:  if (bus_eod) nxt = S_NORM_BIT;
      S_NORM_BIT:  if (bus_norm || tx_ready) nxt = S_SEND_ID;
      S_SEND_ID:   if (seg_end) nxt = S_WAIT_SLOT;
      S_WAIT_SLOT: if (rx_byte_vld) nxt = own_byte ? S_DONE : S_SEND_ID;
      S_DONE:      nxt = S_IDLE;
      default:     nxt = S_IDLE;
    endcase
    if (bus_eof && !own_byte && state != S_IDLE && state != S_DONE) begin
      nxt     = S_IDLE;
      abort_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      act_type <= '0;
      abort    <= 1'b0;
    end else begin
      state <= nxt;
      abort <= abort_n;
      if (state == S_IDLE && nxt == S_WAIT_EOD) act_type <= eff_type;
      else if (nxt == S_IDLE)                   act_type <= '0;
    end
  end
endmodule

// File: rtl/ifr_tx_seq.sv
`timescale 1ns/1ps
module ifr_tx_seq
  import ifr_seq_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int TYPE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [TYPE_W-1:0] cfg_wdata,
  output logic [TYPE_W-1:0] cfg_rdata,
  output logic [TYPE_W-1:0] cfg_eff,
  input  logic              ifr_start,
  input  logic [ID_W-1:0]   node_id,
  input  logic              bus_eod,
  input  logic              bus_eof,
  input  logic              bus_norm,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic              rx_byte_vld,
  input  logic [ID_W-1:0]   rx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic              tx_norm,
  output logic              tx_bit,
  output logic              ifr_busy,
  output logic [TYPE_W-1:0] ifr_type,
  output logic              ifr_done,
  output logic              ifr_abort
);
  seq_state_t state;
  logic norm_valid, bit_valid, bit_val, seg_end, lost;

  ifr_type_cfg #(.TYPE_W(TYPE_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_data(cfg_wdata),
    .raw_q(cfg_rdata), .eff(cfg_eff)
  );

  ifr_seq_ctrl #(.ID_W(ID_W), .TYPE_W(TYPE_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(ifr_start), .eff_type(cfg_eff),
    .bus_eod(bus_eod), .bus_eof(bus_eof), .bus_norm(bus_norm),
    .tx_ready(tx_ready), .seg_end(seg_end), .rx_byte_vld(rx_byte_vld),
    .rx_byte(rx_byte), .node_id(node_id), .state(state),
    .act_type(ifr_type), .norm_valid(norm_valid), .done(ifr_done),
    .abort(ifr_abort)
  );

  ifr_id_tx #(.ID_W(ID_W)) u_idtx (
    .clk(clk), .rst(rst), .en(state == S_SEND_ID), .id(node_id),
    .tx_ready(tx_ready), .echo_vld(rx_bit_vld), .echo_bit(rx_bit),
    .bit_valid(bit_valid), .bit_val(bit_val), .seg_end(seg_end), .lost(lost)
  );

  assign tx_valid = norm_valid | bit_valid;
  assign tx_norm  = norm_valid;
  assign tx_bit   = norm_valid | (bit_valid & bit_val);
  assign ifr_busy = (state != S_IDLE);
endmodule

// File: rtl/ifr_tx_seq_chk.sv
`timescale 1ns/1ps
module ifr_tx_seq_chk #(
  parameter int TYPE_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [TYPE_W-1:0] cfg_rdata,
  input logic [TYPE_W-1:0] cfg_eff,
  input logic              bus_eod,
  input logic              bus_eof,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_norm,
  input logic              tx_bit,
  input logic              ifr_busy,
  input logic [TYPE_W-1:0] ifr_type,
  input logic              ifr_done,
  input logic              ifr_abort
);
  a_r2_eff_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cfg_eff));
  a_r2_eff_nonzero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata != '0) |-> (cfg_eff != '0));
  a_r3_type_idle: assert property (@(posedge clk) disable iff (rst)
    !ifr_busy |-> (ifr_type == '0));
  a_r3_type_busy: assert property (@(posedge clk) disable iff (rst)
    ifr_busy |-> $onehot(ifr_type));
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !ifr_busy |-> !tx_valid);
  a_r4_norm_after_eod: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_norm) |-> $past(bus_eod));
  a_r6_bit_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready && !tx_norm && !bus_eof) |=> (tx_valid && $stable(tx_bit)));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    ifr_done |=> (!ifr_done && !ifr_busy));
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
    ifr_abort |-> (!ifr_busy && !ifr_done));
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (!ifr_busy && cfg_rdata == '0 && !ifr_abort));
endmodule

bind ifr_tx_seq ifr_tx_seq_chk #(.TYPE_W(TYPE_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .cfg_eff(cfg_eff),
  .bus_eod(bus_eod), .bus_eof(bus_eof), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_norm(tx_norm), .tx_bit(tx_bit),
  .ifr_busy(ifr_busy), .ifr_type(ifr_type), .ifr_done(ifr_done),
  .ifr_abort(ifr_abort)
);

// File: tb/ifr_tx_seq_tb.sv
`timescale 1ns/1ps
module ifr_tx_seq_tb;
  localparam int ID_W = 8;
  localparam int TYPE_W = 3;
  // {written value, expected resolved type}
  localparam logic [5:0] CFG_VEC [8] = '{
    {3'b000, 3'b000}, {3'b001, 3'b001}, {3'b010, 3'b010}, {3'b011, 3'b010},
    {3'b100, 3'b100}, {3'b101, 3'b100}, {3'b110, 3'b100}, {3'b111, 3'b100}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cfg_wr, ifr_start, bus_eod, bus_eof, bus_norm;
  logic rx_bit_vld, rx_bit, rx_byte_vld, tx_ready;
  logic [TYPE_W-1:0] cfg_wdata, cfg_rdata, cfg_eff, ifr_type;
  logic [ID_W-1:0] node_id, rx_byte;
  logic tx_valid, tx_norm, tx_bit, ifr_busy, ifr_done, ifr_abort;

  ifr_tx_seq #(.ID_W(ID_W), .TYPE_W(TYPE_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_eff(cfg_eff), .ifr_start(ifr_start),
    .node_id(node_id), .bus_eod(bus_eod), .bus_eof(bus_eof),
    .bus_norm(bus_norm), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_norm(tx_norm), .tx_bit(tx_bit),
    .ifr_busy(ifr_busy), .ifr_type(ifr_type), .ifr_done(ifr_done),
    .ifr_abort(ifr_abort)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [TYPE_W-1:0] v);
    cfg_wr = 1'b1; cfg_wdata = v; cyc(); cfg_wr = 1'b0;
  endtask

  task automatic start_and_eod();
    ifr_start = 1'b1; cyc(); ifr_start = 1'b0;
    bus_eod = 1'b1; cyc(); bus_eod = 1'b0;
  endtask

  // Serialise one ID byte; the echo at bit lose_at reads active (loss).
  task automatic send_byte(input logic [ID_W-1:0] id, input int lose_at);
    for (int i = 0; i < ID_W; i++) begin
      chk("R6 bit offered", tx_valid, 1'b1);
      chk("R6 MSB-first bit value", tx_bit, id[ID_W-1-i]);
      tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
      chk("R6 waits for echo", tx_valid, 1'b0);
      rx_bit_vld = 1'b1;
      rx_bit = (i == lose_at) ? 1'b1 : id[ID_W-1-i];
      cyc(); rx_bit_vld = 1'b0;
      if (i == lose_at) begin
        chk("R7 stop after loss", tx_valid, 1'b0);
        cyc();
        chk("R7 silent until next slot", tx_valid, 1'b0);
        return;
      end
    end
    chk("R6 byte complete, no offer", tx_valid, 1'b0);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_wr = 0; cfg_wdata = '0; ifr_start = 0; bus_eod = 0;
    bus_eof = 0; bus_norm = 0; rx_bit_vld = 0; rx_bit = 0; rx_byte_vld = 0;
    rx_byte = '0; tx_ready = 0; node_id = 8'hA5;
    repeat (3) cyc();
    chk("R10 reset busy", ifr_busy, 1'b0);
    chk("R10 reset rdata", cfg_rdata, 3'b000);
    chk("R10 reset type", ifr_type, 3'b000);
    chk("R10 reset tx_valid", tx_valid, 1'b0);
    rst = 1'b0;

    // Vector table: raw readback and priority resolution.
    for (int k = 0; k < 8; k++) begin
      write_cfg(CFG_VEC[k][5:3]);
      chk("R1 raw readback", cfg_rdata, CFG_VEC[k][5:3]);
      chk("R2 resolved type", cfg_eff, CFG_VEC[k][2:0]);
    end

    // R3: zero type ignores start.
    write_cfg(3'b000);
    ifr_start = 1'b1; cyc(); ifr_start = 1'b0;
    chk("R3 zero type ignored", ifr_busy, 1'b0);
    cyc();
    chk("R3 zero type still idle", ifr_busy, 1'b0);

    // Full run with own normalization and a clean byte.
    write_cfg(3'b011);
    node_id = 8'hA5;
    ifr_start = 1'b1; cyc(); ifr_start = 1'b0;
    chk("R3 accepted busy", ifr_busy, 1'b1);
    chk("R3 latched type", ifr_type, 3'b010);
    repeat (3) begin
      cyc();
      chk("R4 nothing before EOD", tx_valid, 1'b0);
    end
    bus_eod = 1'b1; cyc(); bus_eod = 1'b0;
    chk("R4 norm valid", tx_valid, 1'b1);
    chk("R4 norm kind", tx_norm, 1'b1);
    chk("R4 norm active", tx_bit, 1'b1);
    cyc();
    chk("R6 norm held without ready", tx_norm, 1'b1);
    tx_ready = 1'b1; cyc(); tx_ready = 1'b0;
    chk("R4 norm done, id next", tx_norm, 1'b0);
    send_byte(8'hA5, ID_W);
    rx_byte_vld = 1'b1; rx_byte = 8'hA5; cyc(); rx_byte_vld = 1'b0;
    chk("R8 done pulse", ifr_done, 1'b1);
    cyc();
    chk("R8 done single cycle", ifr_done, 1'b0);
    chk("R8 idle after done", ifr_busy, 1'b0);
    chk("R8 type cleared", ifr_type, 3'b000);

    // Shared normalization, loss on the first bit, retry, completion.
    write_cfg(3'b001);
    node_id = 8'h3C;
    start_and_eod();
    chk("R4 norm offered", tx_norm, 1'b1);
    bus_norm = 1'b1; #0.5;
    chk("R5 own norm withdrawn", tx_valid, 1'b0);
    cyc(); bus_norm = 1'b0; #0.5;
    chk("R5 no own norm", tx_norm, 1'b0);
    chk("R5 straight to id bit", tx_valid, 1'b1);
    send_byte(8'h3C, 0);
    rx_byte_vld = 1'b1; rx_byte = 8'h80; cyc(); rx_byte_vld = 1'b0;
    chk("R7 retry offered", tx_valid, 1'b1);
    chk("R7 retry from MSB", tx_bit, 1'b0);
    chk("R7 still busy", ifr_busy, 1'b1);
    send_byte(8'h3C, ID_W);
    rx_byte_vld = 1'b1; rx_byte = 8'h3C; cyc(); rx_byte_vld = 1'b0;
    chk("R8 done after retry", ifr_done, 1'b1);
    cyc();

    // End-of-frame before own byte.
    write_cfg(3'b100);
    start_and_eod();
    bus_eof = 1'b1; cyc(); bus_eof = 1'b0;
    chk("R9 abort pulse", ifr_abort, 1'b1);
    chk("R9 idle after abort", ifr_busy, 1'b0);
    chk("R9 no done", ifr_done, 1'b0);
    cyc();
    chk("R9 abort single cycle", ifr_abort, 1'b0);

    // Reset in the middle of a response.
    start_and_eod();
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R10 mid-run reset busy", ifr_busy, 1'b0);
    chk("R10 mid-run reset type", ifr_type, 3'b000);
    chk("R10 mid-run reset rdata", cfg_rdata, 3'b000);
    chk("R10 mid-run reset tx_valid", tx_valid, 1'b0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule